// File: doc/BRIEF.md
# Microscaling Exponent Scaler

This unit multiplies one minifloat element by a shared power-of-two block scale. It does this by adding the scale's unbiased exponent to the element's exponent field and clamping the sum. Elements arrive left-aligned in a 32-bit word, with the sign in bit 31 and the exponent starting at bit 30. A format select gives the exponent width. The scale is supplied as an FP32 value, and only its exponent field is used.

The block does not renormalize the mantissa, produce subnormals or round. The sign bit and every bit below the exponent field leave the block unchanged. A scale whose exponent field is all ones forces the format's NaN code. An exponent that would overflow saturates at the all-ones exponent and does not become infinity. An exponent that would underflow is held at 1. The result is registered, so it appears one cycle after the input and is marked by a valid flag.

Top module: `mx_exp_scaler`

## Requirements
- R1: The format select gives the exponent width, and the exponent field occupies bits 30 down to 31-width. The codes are 0 = 4 bits (E4M3), 1 = 5 bits (E5M2), 2 = 5 bits (E5M10), 3 = 8 bits (E8M7) and 4 = 8 bits (FP32).
- R2: The scale amount is scale_in[30:23] minus 127. When the element exponent plus the amount lies in 1 to 2^width-1, that sum becomes the output exponent.
- R3: When the sum exceeds 2^width-1, the output exponent is 2^width-1.
- R4: When the sum is below 1, the output exponent is 1. This includes an element exponent of 0.
- R5: When scale_in[30:23] is 8'hFF and the format code is 0 to 4, elem_out is the format's NaN code, whatever the element is. The codes are 0: FF000000, 1: FF000000, 2: 7C100000, 3: 7F810000 and 4: 7F800100 (hex).
- R6: For format codes 0 to 4 with a non-NaN scale, bit 31 and all bits below the exponent field equal the input's.
- R7: For format codes 5 to 7, elem_out equals elem_in and the scale has no effect, even when its exponent field is 8'hFF.
- R8: out_valid is in_valid delayed by one clock, and elem_out then carries the result for that input. While in_valid is low, elem_out holds its last value.
- R9: After reset, out_valid is 0 and elem_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is present this cycle |
| fmt_sel | input | 3 | Element format code |
| elem_in | input | 32 | Left-aligned minifloat element |
| scale_in | input | 32 | FP32 block scale; only bits 30:23 are used |
| out_valid | output | 1 | elem_out holds a new result |
| elem_out | output | 32 | Scaled element |

## Verification
The assertions assume that in_valid is low while reset is asserted, and that every input is stable and known across each clock edge. Their field checks depend on the format code and scale being stable across the edge on which they are captured. The stimulus meets these assumptions by changing all inputs only on falling edges, and by holding in_valid low through reset and during gaps. The vectors cover every format code, including the reserved ones, and reach the extreme scale amounts of -127 and +127 in both directions and under both clamps.

// File: rtl/mxs_pkg.sv
// Shared constants and format tables for the exponent scaler.
// Assumes elements are left-aligned in a 32-bit word: sign at bit 31,
// exponent field immediately below it.
package mxs_pkg;
    localparam int WORD_W        = 32;
    localparam int SCALE_EXP_LSB = 23;
    localparam int SCALE_EXP_W   = 8;
    localparam int SCALE_BIAS    = 127;
    localparam int NUM_FMT       = 5;
    localparam int SUM_W         = 10;
    localparam int SEL_W         = 3;

    typedef enum logic [SEL_W-1:0] {
        FMT_E4M3  = 3'd0,
        FMT_E5M2  = 3'd1,
        FMT_E5M10 = 3'd2,
        FMT_E8M7  = 3'd3,
        FMT_FP32  = 3'd4
    } fmt_e;

    // Exponent field width per format code
    function automatic int exp_width(input int f);
        case (f)
            0:       return 4;
            1, 2:    return 5;
            default: return 8;
        endcase
    endfunction

    // Left-aligned NaN code per format code
    function automatic logic [WORD_W-1:0] nan_code(input int f);
        case (f)
            0, 1:    return 32'hFF00_0000;
            2:       return 32'h7C10_0000;
            3:       return 32'h7F81_0000;
            default: return 32'h7F80_0100;
        endcase
    endfunction
endpackage

// File: rtl/mxs_scale_decode.sv
// Turns an FP32 scale word into a signed shift amount and a NaN flag.
// Assumes only the FP32 exponent field matters; sign and mantissa ignored.
module mxs_scale_decode
    import mxs_pkg::*;
#(
    parameter int SW = SUM_W
) (
    input  logic [WORD_W-1:0]    scale_in,
    output logic signed [SW-1:0] amount,
    output logic                 force_nan
);
    logic [SCALE_EXP_W-1:0] sexp;

    // Extract the scale exponent, remove the bias, flag the all-ones code
    always_comb begin
        sexp      = scale_in[SCALE_EXP_LSB +: SCALE_EXP_W];
        amount    = $signed({{(SW-SCALE_EXP_W){1'b0}}, sexp}) - SW'(SCALE_BIAS);
        force_nan = (sexp == {SCALE_EXP_W{1'b1}});
    end
endmodule

// File: rtl/mxs_exp_clamp.sv
// Adds a signed amount to one format's exponent field and clamps the sum
// to the range 1 .. 2^EW-1. Sign and lower bits are copied unchanged.
// Assumes the exponent field sits at bits 30 down to 31-EW.
module mxs_exp_clamp
    import mxs_pkg::*;
#(
    parameter int EW = 4,
    parameter int SW = SUM_W
) (
    input  logic [WORD_W-1:0]    elem,
    input  logic signed [SW-1:0] amount,
    output logic [WORD_W-1:0]    word
);
    localparam int EXP_HI = WORD_W - 2;
    localparam logic signed [SW-1:0] MAX_E = SW'((1 << EW) - 1);
    localparam logic signed [SW-1:0] MIN_E = SW'(1);

    logic [EW-1:0]        e_in;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] clamped;

    // Widen, add and saturate the exponent, then splice it back in
    always_comb begin
        e_in = elem[EXP_HI -: EW];
        sum  = $signed({{(SW-EW){1'b0}}, e_in}) + amount;
        if (sum > MAX_E)
            clamped = MAX_E;
        else if (sum < MIN_E)
            clamped = MIN_E;
        else
            clamped = sum;
        word                = elem;
        word[EXP_HI -: EW]  = clamped[EW-1:0];
    end
endmodule

// File: rtl/mxs_fmt_select.sv
// Picks the scaled word for the selected format, or the format's NaN code,
// or the untouched element for reserved codes.
module mxs_fmt_select
    import mxs_pkg::*;
#(
    parameter int NF = NUM_FMT
) (
    input  logic [WORD_W-1:0] cand [NF],
    input  logic [SEL_W-1:0]  fmt_sel,
    input  logic [WORD_W-1:0] elem_in,
    input  logic              force_nan,
    output logic [WORD_W-1:0] result
);
    logic [WORD_W-1:0] nan_tab [NF];

    // Build the NaN constant table from the package
    for (genvar g = 0; g < NF; g++) begin : g_nan
        assign nan_tab[g] = nan_code(g);
    end

    // Route by format code; reserved codes bypass
    always_comb begin
        result = elem_in;
        for (int i = 0; i < NF; i++) begin
            if (fmt_sel == SEL_W'(i))
                result = force_nan ? nan_tab[i] : cand[i];
        end
    end
endmodule

// File: rtl/mx_exp_scaler.sv
// Top of the exponent scaler: decodes the scale, runs one clamp slice per
// format, selects, and registers the result with a valid flag.
// Assumes in_valid is low during reset; one-cycle latency.
module mx_exp_scaler
    import mxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  fmt_sel,
    input  logic [WORD_W-1:0] elem_in,
    input  logic [WORD_W-1:0] scale_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] elem_out
);
    logic signed [SUM_W-1:0] amount;
    logic                    force_nan;
    logic [WORD_W-1:0]       cand [NUM_FMT];
    logic [WORD_W-1:0]       result;

    mxs_scale_decode #(.SW(SUM_W)) u_dec (
        .scale_in  (scale_in),
        .amount    (amount),
        .force_nan (force_nan)
    );

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        mxs_exp_clamp #(.EW(exp_width(g)), .SW(SUM_W)) u_clamp (
            .elem   (elem_in),
            .amount (amount),
            .word   (cand[g])
        );
    end

    mxs_fmt_select #(.NF(NUM_FMT)) u_sel (
        .cand      (cand),
        .fmt_sel   (fmt_sel),
        .elem_in   (elem_in),
        .force_nan (force_nan),
        .result    (result)
    );

    // Output register: capture on valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            elem_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                elem_out <= result;
        end
    end
endmodule

// File: rtl/mx_exp_scaler_chk.sv
// Port-level properties of the exponent scaler, bound to the top module.
module mx_exp_scaler_chk
    import mxs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [SEL_W-1:0]  fmt_sel,
    input logic [WORD_W-1:0] elem_in,
    input logic [WORD_W-1:0] scale_in,
    input logic              out_valid,
    input logic [WORD_W-1:0] elem_out
);
    logic scale_nan;
    assign scale_nan = (scale_in[30:23] == 8'hFF);

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(elem_out)));
    // R6
    low_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !scale_nan) |=> (elem_out[22:0] == $past(elem_in[22:0])
                                      && elem_out[31] == $past(elem_in[31])));
    // R5
    fp32_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scale_nan && fmt_sel == 3'd4) |=> (elem_out == 32'h7F80_0100));
    // R7
    reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt_sel > 3'd4) |=> (elem_out == $past(elem_in)));
    // R4
    e4m3_exp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !scale_nan && fmt_sel == 3'd0) |=> (elem_out[30:27] != 4'd0));
endmodule

bind mx_exp_scaler mx_exp_scaler_chk chk_i (.*);

// File: tb/mx_exp_scaler_tb_top.sv
`timescale 1ns/1ps
module mx_exp_scaler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic [31:0] elem_in = '0;
    logic [31:0] scale_in = '0;
    logic        out_valid;
    logic [31:0] elem_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] last_exp = '0;

    always #2 clk = ~clk;

    mx_exp_scaler dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
        .elem_in(elem_in), .scale_in(scale_in),
        .out_valid(out_valid), .elem_out(elem_out)
    );

    // Reference computed from the requirements
    function automatic logic [31:0] model(input logic [31:0] e, input logic [2:0] f,
                                          input logic [31:0] s);
        int ew, lsb, ex, amt, sum;
        logic [31:0] m;
        if (f > 3'd4) return e;                              // R7
        ew = (f == 0) ? 4 : (f <= 2) ? 5 : 8;                // R1
        if (s[30:23] == 8'hFF) begin                         // R5
            case (f)
                0, 1: return 32'hFF00_0000;
                2:    return 32'h7C10_0000;
                3:    return 32'h7F81_0000;
                default: return 32'h7F80_0100;
            endcase
        end
        lsb = 31 - ew;
        m   = ((32'd1 << ew) - 1) << lsb;
        ex  = int'((e & m) >> lsb);
        amt = int'(s[30:23]) - 127;                          // R2
        sum = ex + amt;
        if (sum > (1 << ew) - 1) sum = (1 << ew) - 1;        // R3
        if (sum < 1) sum = 1;                                // R4
        return (e & ~m) | ((32'(sum) << lsb) & m);           // R6
    endfunction

    function automatic logic [31:0] pow2(input int k);
        return {1'b0, 8'(k + 127), 23'd0};
    endfunction

    task automatic send(input logic [31:0] e, input logic [2:0] f,
                        input logic [31:0] s, input string tag);
        @(negedge clk);
        elem_in  = e;
        fmt_sel  = f;
        scale_in = s;
        in_valid = 1'b1;
        exp_q.push_back(model(e, f, s));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            elem_in  = 32'hDEAD_BEEF;
            scale_in = 32'h7F80_0000;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops and compares each produced result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                last_exp = exp_q.pop_front();
                check(tag_q.pop_front(), elem_out, last_exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 out_valid reset", {31'd0, out_valid}, 32'd0);
        check("R9 elem_out reset", elem_out, 32'd0);
        rst_n = 1'b1;

        send(32'h3F80_0000, 3'd4, pow2(3),    "R2 fp32 scale up");
        send(32'h3855_5555, 3'd0, pow2(-2),   "R2 e4m3 scale down");
        send(32'h3D00_0000, 3'd0, pow2(10),   "R3 e4m3 upper clamp");
        send(32'hBE12_3456, 3'd1, pow2(127),  "R3 e5m2 max amount");
        send(32'h4000_00FF, 3'd2, pow2(-127), "R4 e5m10 min amount");
        send(32'h0012_3456, 3'd3, pow2(0),    "R4 e8m7 zero exponent");
        send(32'hC1AB_CDEF, 3'd3, pow2(-5),   "R1 e8m7 field");
        send(32'h5A5A_5A5A, 3'd2, pow2(4),    "R1 e5m10 field");
        send(32'h9876_5432, 3'd4, pow2(-20),  "R6 fp32 sign keep");
        send(32'h1234_5678, 3'd0, 32'h7F80_0000, "R5 e4m3 nan");
        send(32'h1234_5678, 3'd1, 32'hFFC0_0001, "R5 e5m2 nan");
        send(32'h0000_0000, 3'd2, 32'h7F80_0000, "R5 e5m10 nan");
        send(32'hFFFF_FFFF, 3'd3, 32'h7F80_0000, "R5 e8m7 nan");
        send(32'h3F80_0000, 3'd4, 32'h7F80_0000, "R5 fp32 nan");
        send(32'h3F80_0000, 3'd5, pow2(9),    "R7 reserved 5");
        send(32'hABCD_0123, 3'd6, 32'h7F80_0000, "R7 reserved 6 nan scale");
        send(32'h7800_0000, 3'd7, pow2(-100), "R7 reserved 7");
        send(32'h7800_0001, 3'd0, pow2(-1),   "R2 e4m3 top exponent");
        idle(3);
        check("R8 out_valid low in gap", {31'd0, out_valid}, 32'd0);
        check("R8 elem_out held", elem_out, last_exp);
        send(32'h4480_0000, 3'd1, pow2(-3),   "R8 after gap");
        idle(2);
        check("R8 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule